// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Controller

This block sits between a synchronous serial shifter and a processor bus. It holds received frames in an 8-deep, 16-bit receive FIFO and frames waiting to go out in an 8-deep, 16-bit transmit FIFO. From the state of these two FIFOs it derives four interrupt conditions. It combines the enabled conditions into one registered interrupt line.

The shifter is not part of the block. It delivers each completed incoming frame as a one-cycle strobe with its data. It takes outgoing frames from the head of the transmit FIFO with a one-cycle consume strobe. A bit-rate tick input paces the receive timeout.

Software uses a small register port with five word addresses:

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | data | pops the receive FIFO | pushes the transmit FIFO |
| 1 | enable mask | current mask | sets the mask |
| 2 | raw status | conditions, unmasked | no effect |
| 3 | masked status | conditions AND mask | no effect |
| 4 | clear | no effect | write-one-to-clear the sticky bits |

The condition bits have the same positions in the mask, raw, masked and clear registers:

| Bit | Condition |
|---|---|
| 0 | receive overrun |
| 1 | receive timeout |
| 2 | receive FIFO half full |
| 3 | transmit FIFO half empty |

Top module: `sport_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, raw status reads 0x0008 (only transmit half-empty set), masked status reads 0 and irq_o is 0.
- R2: Raw status (address 2) shows every asserted condition whatever the mask holds. Masked status (address 3) equals raw status AND mask. The bits are 0 = overrun, 1 = timeout, 2 = receive half full and 3 = transmit half empty.
- R3: Received frames are read from address 0 in arrival order. Each read with reg_rd_i pops one frame. A read of address 0 while the receive FIFO is empty returns 0 and changes nothing.
- R4: A frame strobe that arrives while the receive FIFO is full, with no pop in the same cycle, sets raw bit 0. Its data replaces the most recently stored frame, and the occupancy stays at 8.
- R5: Raw bit 1 sets on the 32nd bit_tick_i pulse counted while the receive FIFO is non-empty. The count restarts on every receive FIFO read and on every frame written into the FIFO, including an overwrite.
- R6: Raw bit 2 is 1 exactly while the receive FIFO holds 4 or more frames.
- R7: Raw bit 3 is 1 exactly while the transmit FIFO holds 4 or fewer frames. Writes to address 0 push frames, which leave on tx_frame_data_o in order. A push to a full transmit FIFO is dropped, and tx_take_i on an empty FIFO is ignored.
- R8: Raw bits 0 and 1 are sticky until a 1 is written to the same bit of address 4. An event in the same cycle as the clear wins, and the bit stays set.
- R9: irq_o equals the OR of the four masked status bits one clock earlier.
- R10: Bits 15:4 of the mask, raw and masked registers read 0. Mask writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| rx_frame_vld_i | input | 1 | shifter completed an incoming frame |
| rx_frame_data_i | input | 16 | data of the completed frame |
| tx_take_i | input | 1 | shifter consumes the head transmit frame |
| tx_frame_data_o | output | 16 | head of the transmit FIFO |
| tx_avail_o | output | 1 | transmit FIFO non-empty |
| bit_tick_i | input | 1 | bit-rate enable pulse |
| reg_wr_i | input | 1 | register write strobe |
| reg_rd_i | input | 1 | register read strobe |
| reg_addr_i | input | 3 | register word address |
| reg_wdata_i | input | 16 | write data |
| reg_rdata_o | output | 16 | read data for reg_addr_i, combinational |
| irq_o | output | 1 | combined registered interrupt |

## Verification
The receive FIFO is filled step by step through the half-full threshold and then past full. Overflowing frames separate overwriting the newest entry from dropping the new frame or overwriting the oldest. One overflow lands in the same cycle as a clear write, which shows whether the event or the clear has priority.

Tick bursts of 31 and 32 pulses, with a read in between, show whether the timeout fires exactly at the period and whether a read restarts the count. Transmit pushes below, at and above the four-entry mark show the threshold edge. A push into a full transmit FIFO shows whether the overflow frame is dropped. Changing the mask while conditions stay fixed separates raw status from masked status and checks the one-cycle delay of irq_o.

// File: rtl/sport_irq_pkg.sv
package sport_irq_pkg;
  localparam int unsigned FRAME_W  = 16;
  localparam int unsigned FIFO_D   = 8;
  localparam int unsigned TO_TICKS = 32;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned N_IRQ    = 4;

  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
  localparam logic [ADDR_W-1:0] A_RAW  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MIS  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;

  // condition bit positions, shared by all status registers
  localparam int unsigned B_ROR  = 0;
  localparam int unsigned B_RT   = 1;
  localparam int unsigned B_RXHF = 2;
  localparam int unsigned B_TXHE = 3;
endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ovw_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_prev;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign wr_prev = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push)                   mem_q[wr_ptr_q] <= wdata_i;
    else if (ovw_i && !empty_o)    mem_q[wr_prev]  <= wdata_i;
  end
endmodule

// File: rtl/sport_rx_timeout.sv
module sport_rx_timeout #(
  parameter int unsigned TICKS = 32,
  localparam int unsigned TW   = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic nonempty_i,
  input  logic tick_i,
  output logic fire_o
);
  localparam logic [TW-1:0] LIMIT = TW'(TICKS);
  logic [TW-1:0] cnt_q;

  assign fire_o = tick_i && nonempty_i && !restart_i && (cnt_q == LIMIT - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !nonempty_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;  // saturates after firing
  end
endmodule

// File: rtl/sport_irq_regs.sv
module sport_irq_regs
  import sport_irq_pkg::*;
#(
  parameter int unsigned DW = FRAME_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_head_i,
  input  logic          rx_empty_i,
  input  logic          ror_evt_i,
  input  logic          rt_evt_i,
  input  logic          rxhf_i,
  input  logic          txhe_i,
  output logic          rx_pop_o,
  output logic          tx_push_o,
  output logic [N_IRQ-1:0] raw_o,
  output logic [N_IRQ-1:0] mask_o,
  output logic          irq_o
);
  logic [N_IRQ-1:0] mask_q, raw, mis;
  logic             ror_q, rt_q, clr_wr;

  assign clr_wr    = wr_i && (addr_i == AW'(A_CLR));
  assign rx_pop_o  = rd_i && (addr_i == AW'(A_DATA)) && !rx_empty_i;
  assign tx_push_o = wr_i && (addr_i == AW'(A_DATA));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ror_q  <= 1'b0;
      rt_q   <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_i && addr_i == AW'(A_MASK)) mask_q <= wdata_i[N_IRQ-1:0];
      // event beats clear
      if (ror_evt_i)                      ror_q <= 1'b1;
      else if (clr_wr && wdata_i[B_ROR])  ror_q <= 1'b0;
      if (rt_evt_i)                       rt_q  <= 1'b1;
      else if (clr_wr && wdata_i[B_RT])   rt_q  <= 1'b0;
      irq_o <= |mis;
    end
  end

  always_comb begin
    raw         = '0;
    raw[B_ROR]  = ror_q;
    raw[B_RT]   = rt_q;
    raw[B_RXHF] = rxhf_i;
    raw[B_TXHE] = txhe_i;
  end
  assign mis    = raw & mask_q;
  assign raw_o  = raw;
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(A_DATA): rdata_o = rx_empty_i ? '0 : rx_head_i;
      AW'(A_MASK): rdata_o[N_IRQ-1:0] = mask_q;
      AW'(A_RAW):  rdata_o[N_IRQ-1:0] = raw;
      AW'(A_MIS):  rdata_o[N_IRQ-1:0] = mis;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sport_irq_ctrl.sv
module sport_irq_ctrl
  import sport_irq_pkg::*;
#(
  parameter int unsigned DW     = FRAME_W,
  parameter int unsigned DEPTH  = FIFO_D,
  parameter int unsigned TICKS  = TO_TICKS,
  parameter int unsigned AW     = ADDR_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_frame_vld_i,
  input  logic [DW-1:0] rx_frame_data_i,
  input  logic          tx_take_i,
  output logic [DW-1:0] tx_frame_data_o,
  output logic          tx_avail_o,
  input  logic          bit_tick_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_count, tx_count;
  logic rx_full, rx_empty, tx_full, tx_empty;
  logic rx_pop, rx_push, rx_ovw, tx_push;
  logic rt_evt;
  logic [N_IRQ-1:0] raw, mask;

  assign rx_push = rx_frame_vld_i && (!rx_full || rx_pop);
  assign rx_ovw  = rx_frame_vld_i && rx_full && !rx_pop;

  sport_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .pop_i(rx_pop), .ovw_i(rx_ovw),
    .wdata_i(rx_frame_data_i), .rdata_o(rx_head),
    .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  sport_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .pop_i(tx_take_i), .ovw_i(1'b0),
    .wdata_i(reg_wdata_i), .rdata_o(tx_frame_data_o),
    .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );
  assign tx_avail_o = !tx_empty;

  sport_rx_timeout #(.TICKS(TICKS)) u_rx_to (
    .clk_i, .rst_ni,
    .restart_i(rx_frame_vld_i || rx_pop),
    .nonempty_i(!rx_empty),
    .tick_i(bit_tick_i),
    .fire_o(rt_evt)
  );

  sport_irq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .rx_head_i(rx_head), .rx_empty_i(rx_empty),
    .ror_evt_i(rx_ovw), .rt_evt_i(rt_evt),
    .rxhf_i(rx_count >= HALF), .txhe_i(tx_count <= HALF),
    .rx_pop_o(rx_pop), .tx_push_o(tx_push),
    .raw_o(raw), .mask_o(mask), .irq_o
  );
endmodule

// File: rtl/sport_irq_ctrl_chk.sv
module sport_irq_ctrl_chk
  import sport_irq_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_D,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = FRAME_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_frame_vld_i,
  input logic          rx_full,
  input logic          rx_pop,
  input logic [CW-1:0] rx_count,
  input logic [N_IRQ-1:0] raw,
  input logic [N_IRQ-1:0] mask,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          irq_o
);
  p_irq_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(raw & mask)));

  p_ovr_count_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_vld_i && rx_full && !rx_pop) |=> $stable(rx_count));

  p_ovr_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_vld_i && rx_full && !rx_pop) |=> raw[B_ROR]);

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw[B_ROR] && !(reg_wr_i && reg_addr_i == AW'(A_CLR) && reg_wdata_i[B_ROR])) |=> raw[B_ROR]);

  p_rt_needs_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw[B_RT]) |-> $past(rx_count != '0));

  p_rx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));

  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != AW'(A_DATA)) |-> (reg_rdata_o[DW-1:N_IRQ] == '0));
endmodule

bind sport_irq_ctrl sport_irq_ctrl_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
  .clk_i, .rst_ni, .rx_frame_vld_i, .rx_full, .rx_pop, .rx_count,
  .raw, .mask, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
);

// File: tb/sport_irq_ctrl_tb_top.sv
module sport_irq_ctrl_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_frame_vld_i = 1'b0, tx_take_i = 1'b0, bit_tick_i = 1'b0;
  logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [15:0] rx_frame_data_i = '0, reg_wdata_i = '0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] tx_frame_data_o, reg_rdata_o;
  logic tx_avail_o, irq_o;

  int checks = 0, errors = 0;
  logic [15:0] rx_exp[$];
  logic [15:0] tx_exp[$];

  always #2.5 clk_i = ~clk_i;

  sport_irq_ctrl dut_i (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1; #1; d = reg_rdata_o;
    cyc(); reg_rd_i = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [2:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d); check(req, d, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    if (a == 3'd0 && tx_exp.size() < 8) tx_exp.push_back(d);
    cyc(); reg_wr_i = 1'b0;
  endtask

  // driver: shifter delivers a frame, expected queue follows the overwrite rule
  task automatic rx_frame(input logic [15:0] d, input bit with_clr = 0);
    rx_frame_vld_i = 1'b1; rx_frame_data_i = d;
    if (with_clr) begin reg_addr_i = 3'd4; reg_wdata_i = 16'h0001; reg_wr_i = 1'b1; end
    if (rx_exp.size() == 8) rx_exp[7] = d; else rx_exp.push_back(d);
    cyc(); rx_frame_vld_i = 1'b0; reg_wr_i = 1'b0;
  endtask

  // monitor: pops a received frame and compares with the queue
  task automatic rx_pop_chk(string req);
    logic [15:0] d, e;
    e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 16'h0000;
    rd(3'd0, d); check(req, d, e);
  endtask

  task automatic tx_take_chk(string req);
    logic [15:0] e;
    e = tx_exp.pop_front();
    #1; check(req, tx_frame_data_o, e);
    tx_take_i = 1'b1; cyc(); tx_take_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin bit_tick_i = 1'b1; cyc(); bit_tick_i = 1'b0; end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cyc();
    // R1 reset state
    expect_reg("R1 mask", 3'd1, 16'h0000);
    expect_reg("R1 raw", 3'd2, 16'h0008);
    expect_reg("R1 masked", 3'd3, 16'h0000);
    check("R1 irq", {15'd0, irq_o}, 16'h0000);
    // R3 empty read
    expect_reg("R3 empty read", 3'd0, 16'h0000);
    // R6 threshold
    for (int i = 0; i < 3; i++) rx_frame(16'hA000 + 16'(i));
    expect_reg("R6 three frames", 3'd2, 16'h0008);
    rx_frame(16'hA003);
    expect_reg("R6 four frames", 3'd2, 16'h000C);
    for (int i = 4; i < 8; i++) rx_frame(16'hA000 + 16'(i));
    expect_reg("R4 full no overrun", 3'd2, 16'h000C);
    // R4 overrun
    rx_frame(16'hB008);
    expect_reg("R4 overrun raw", 3'd2, 16'h000D);
    expect_reg("R2 masked zero with mask 0", 3'd3, 16'h0000);
    // R2 / R9 mask
    wr(3'd1, 16'h0001);
    check("R9 irq one cycle late", {15'd0, irq_o}, 16'h0000);
    expect_reg("R2 masked overrun", 3'd3, 16'h0001);
    check("R9 irq asserted", {15'd0, irq_o}, 16'h0001);
    // R10 reserved bits
    wr(3'd1, 16'hFFF4);
    expect_reg("R10 mask reserved", 3'd1, 16'h0004);
    expect_reg("R2 masked half-full", 3'd3, 16'h0004);
    wr(3'd1, 16'h0001);
    // R8 event beats clear, R4 overwrite newest
    rx_frame(16'hC009, 1);
    expect_reg("R8 event wins over clear", 3'd2, 16'h000D);
    wr(3'd4, 16'h0001);
    expect_reg("R8 cleared", 3'd2, 16'h000C);
    check("R9 irq low after clear", {15'd0, irq_o}, 16'h0000);
    // R3 / R4 order with newest overwritten
    for (int i = 0; i < 8; i++) rx_pop_chk("R4 rx order");
    expect_reg("R3 read after drain", 3'd0, 16'h0000);
    expect_reg("R6 empty raw", 3'd2, 16'h0008);
    // R5 timeout
    rx_frame(16'hD000);
    rx_frame(16'hD001);
    ticks(20);
    rx_pop_chk("R5 pop restarts");
    ticks(31);
    expect_reg("R5 31 ticks", 3'd2, 16'h0008);
    ticks(1);
    expect_reg("R5 32 ticks", 3'd2, 16'h000A);
    wr(3'd1, 16'h0002);
    cyc();
    check("R9 irq timeout", {15'd0, irq_o}, 16'h0001);
    wr(3'd4, 16'h0002);
    expect_reg("R8 timeout cleared", 3'd2, 16'h0008);
    rx_pop_chk("R5 last frame");
    ticks(40);
    expect_reg("R5 no timeout empty", 3'd2, 16'h0008);
    wr(3'd1, 16'h0000);
    // R7 tx thresholds
    for (int i = 0; i < 4; i++) wr(3'd0, 16'hE000 + 16'(i));
    expect_reg("R7 four tx", 3'd2, 16'h0008);
    wr(3'd0, 16'hE004);
    expect_reg("R7 five tx", 3'd2, 16'h0000);
    for (int i = 5; i < 9; i++) wr(3'd0, 16'hE000 + 16'(i));
    tx_take_chk("R7 tx order");
    expect_reg("R7 after take seven", 3'd2, 16'h0000);
    for (int i = 0; i < 3; i++) tx_take_chk("R7 tx order");
    expect_reg("R7 four left", 3'd2, 16'h0008);
    for (int i = 0; i < 4; i++) tx_take_chk("R7 tx order drop on full");
    check("R7 tx empty", {15'd0, tx_avail_o}, 16'h0000);
    tx_take_i = 1'b1; cyc(); tx_take_i = 1'b0;
    expect_reg("R7 take on empty ignored", 3'd2, 16'h0008);
    wr(3'd0, 16'h1234);
    tx_take_chk("R7 after empty take");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule